// File: doc/BRIEF.md
# USB Endpoint-Zero Control/Status Register

This block is the device-side control and status register for USB endpoint 0. It holds three handshake flags: receive-ready, transmit-ready and data-end. It also tracks which phase a control transfer is in: idle, IN data, or OUT data. Firmware reaches the register through a single-cycle write port and a combinational read port. The packet engine reports two events with one-cycle strobes: a packet has landed in the FIFO, and an armed packet has left the FIFO.

The data-end flag tells the engine that the current packet is the last one of the data stage. Firmware can raise it only in the same write that completes a handshake. That handshake is either arming a transmit packet (a final or zero-length one) or releasing a received packet it has just unloaded. The hardware lowers the flag on the next packet event in either direction. Every packet event also produces a one-cycle interrupt request.

Top module: `usb_ep0_csr`

## Requirements
- R1: After a synchronous reset, rd_data reads all zeros (all flags clear, phase IDLE) and irq is low.
- R2: RxPktRdy (read bit 0) is set the cycle after pkt_rx. A write with bit 6 = 1 clears it, and writing 0 there has no effect. When pkt_rx and that clear arrive in the same cycle, the flag stays set.
- R3: TxPktRdy (read bit 1) is set by a write with bit 1 = 1. pkt_tx_done clears it only while it is set, and a pkt_tx_done while it is clear is ignored. When a re-arm and a completion arrive in the same cycle, the flag stays set.
- R4: DataEnd (bit 3) is set by a write with bit 3 = 1, but only when the same write has bit 1 = 1, or has bit 6 = 1 while RxPktRdy is 1. Any other write leaves DataEnd unchanged, including a write of 0.
- R5: DataEnd is cleared the cycle after any pkt_rx, or after a pkt_tx_done that completes an armed packet.
- R6: When a clearing event and a valid DataEnd set fall in the same cycle, DataEnd ends up set, and it clears at the following packet event.
- R7: The phase reads on bits 5:4 as IDLE=0, TX=1, RX=2. From IDLE, pkt_rx enters RX. Otherwise, from IDLE, arming a transmit enters TX.
- R8: In RX, a write that releases a held packet (bit 6 = 1 while RxPktRdy is 1) and also has bit 3 = 1 returns to IDLE. Any other release leaves the phase in RX.
- R9: In TX, completing an armed packet while DataEnd is 1 returns to IDLE. A completion with DataEnd at 0 stays in TX.
- R10: irq is high for exactly the cycle after each cycle with pkt_rx or a valid completion. A pkt_rx and a completion in the same cycle give one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | DATA_W | CPU write data (bit 1 arm, bit 3 data-end, bit 6 release) |
| pkt_rx | input | 1 | Packet engine: packet stored in FIFO |
| pkt_tx_done | input | 1 | Packet engine: armed packet sent |
| rd_data | output | DATA_W | Status readback |
| irq | output | 1 | One-cycle endpoint-0 interrupt request |

## Verification
Two things can land on the same edge. One is a hardware packet event that clears DataEnd. The other is a CPU write that sets it: a release of a held packet, or an arm of a transmit. The bench drives both in one cycle on purpose. It then checks that the flag reads 1, and that a later packet event, with no write in between, clears it. The bench also lines up a receive with a release, and a completion with a re-arm. In both cases it expects the set to win. A long randomized stretch keeps landing such collisions, and a behavioural model judges each cycle.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    localparam int RX_RDY_BIT  = 0;
    localparam int TX_RDY_BIT  = 1;
    localparam int DEND_BIT    = 3;
    localparam int PHASE_LSB   = 4;
    localparam int PHASE_W     = 2;
    localparam int RX_SVC_BIT  = 6;
    localparam int MIN_DATA_W  = 7;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'd0,
        PH_TX   = 2'd1,
        PH_RX   = 2'd2
    } ep0_phase_e;

    typedef struct packed {
        logic arm_tx;
        logic rx_release;
        logic de_set;
    } cpu_req_t;

    typedef struct packed {
        logic rx_evt;
        logic tx_evt;
    } pkt_evt_t;

    typedef struct packed {
        logic       rx_rdy;
        logic       tx_rdy;
        logic       data_end;
        ep0_phase_e phase;
    } ep0_state_t;

    function automatic logic any_event(input pkt_evt_t e);
        return e.rx_evt | e.tx_evt;
    endfunction

endpackage

// File: rtl/ep0_req_decode.sv
module ep0_req_decode
    import ep0_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rx_rdy,
    input  logic              tx_rdy,
    input  logic              pkt_rx,
    input  logic              pkt_tx_done,
    output cpu_req_t          req,
    output pkt_evt_t          evt
);
    logic arm, release_ok;

    always_comb begin
        arm        = wr_en & wr_data[TX_RDY_BIT];
        release_ok = wr_en & wr_data[RX_SVC_BIT] & rx_rdy;
        req.arm_tx     = arm;
        req.rx_release = release_ok;
        // data-end rides only on a handshake write
        req.de_set     = wr_en & wr_data[DEND_BIT] & (arm | release_ok);
        evt.rx_evt     = pkt_rx;
        evt.tx_evt     = pkt_tx_done & tx_rdy;
    end
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank
    import ep0_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_req_t req,
    input  pkt_evt_t evt,
    output logic     rx_rdy,
    output logic     tx_rdy,
    output logic     data_end
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_rdy   <= 1'b0;
            tx_rdy   <= 1'b0;
            data_end <= 1'b0;
        end else begin
            if (evt.rx_evt)          rx_rdy <= 1'b1;
            else if (req.rx_release) rx_rdy <= 1'b0;

            if (req.arm_tx)          tx_rdy <= 1'b1;
            else if (evt.tx_evt)     tx_rdy <= 1'b0;

            if (req.de_set)          data_end <= 1'b1;
            else if (any_event(evt)) data_end <= 1'b0;
        end
    end
endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
    import ep0_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cpu_req_t   req,
    input  pkt_evt_t   evt,
    input  logic       data_end,
    output ep0_phase_e phase
);
    ep0_phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: begin
                if (evt.rx_evt)      nxt = PH_RX;
                else if (req.arm_tx) nxt = PH_TX;
            end
            PH_TX: begin
                if (evt.tx_evt && data_end) nxt = PH_IDLE;
            end
            PH_RX: begin
                if (req.rx_release && req.de_set) nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/ep0_irq_pulse.sv
module ep0_irq_pulse
    import ep0_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pkt_evt_t evt,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_event(evt);
    end
endmodule

// File: rtl/usb_ep0_csr.sv
module usb_ep0_csr
    import ep0_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pkt_rx,
    input  logic              pkt_tx_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int PH_MSB = PHASE_LSB + PHASE_W - 1;

    cpu_req_t   req;
    pkt_evt_t   evt;
    ep0_state_t st;

    ep0_req_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rx_rdy      (st.rx_rdy),
        .tx_rdy      (st.tx_rdy),
        .pkt_rx      (pkt_rx),
        .pkt_tx_done (pkt_tx_done),
        .req         (req),
        .evt         (evt)
    );

    ep0_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .evt      (evt),
        .rx_rdy   (st.rx_rdy),
        .tx_rdy   (st.tx_rdy),
        .data_end (st.data_end)
    );

    ep0_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .evt      (evt),
        .data_end (st.data_end),
        .phase    (st.phase)
    );

    ep0_irq_pulse u_irq (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .irq (irq)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[RX_RDY_BIT]        = st.rx_rdy;
        rd_data[TX_RDY_BIT]        = st.tx_rdy;
        rd_data[DEND_BIT]          = st.data_end;
        rd_data[PH_MSB:PHASE_LSB]  = st.phase;
    end
endmodule

// File: rtl/ep0_csr_checker.sv
module ep0_csr_checker
    import ep0_csr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              pkt_rx,
    input logic              pkt_tx_done,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq
);
    logic rx_q, tx_q, de_q;
    logic [1:0] ph_q;
    assign rx_q = rd_data[RX_RDY_BIT];
    assign tx_q = rd_data[TX_RDY_BIT];
    assign de_q = rd_data[DEND_BIT];
    assign ph_q = rd_data[PHASE_LSB+1:PHASE_LSB];

    p_rx_set_r2: assert property (@(posedge clk) disable iff (rst)
        pkt_rx |=> rx_q);

    p_tx_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_tx_done && tx_q && !(wr_en && wr_data[TX_RDY_BIT])) |=> !tx_q);

    p_de_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(de_q) |-> $past(wr_en && wr_data[DEND_BIT] &&
            (wr_data[TX_RDY_BIT] || (wr_data[RX_SVC_BIT] && rx_q))));

    p_de_autoclear_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_rx && !(wr_en && wr_data[DEND_BIT])) |=> !de_q);

    p_phase_legal_r7: assert property (@(posedge clk) disable iff (rst)
        ph_q != 2'd3);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pkt_rx || (pkt_tx_done && tx_q)));
endmodule

bind usb_ep0_csr ep0_csr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .pkt_rx      (pkt_rx),
    .pkt_tx_done (pkt_tx_done),
    .rd_data     (rd_data),
    .irq         (irq)
);

// File: tb/usb_ep0_csr_tb.sv
`timescale 1ns/1ps
module usb_ep0_csr_tb;
    localparam int DW = 8;
    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, pkt_rx = 1'b0, pkt_tx_done = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic irq;

    int vectors = 0, miscompares = 0;
    bit m_rx, m_tx, m_de, m_irq;
    int m_ph;

    always #4 clk = ~clk;

    usb_ep0_csr #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pkt_rx(pkt_rx), .pkt_tx_done(pkt_tx_done),
        .rd_data(rd_data), .irq(irq));

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "rx_rdy(R2)", int'(rd_data[0]), int'(m_rx));
        chk(req, "tx_rdy(R3)", int'(rd_data[1]), int'(m_tx));
        chk(req, "data_end(R5)", int'(rd_data[3]), int'(m_de));
        chk(req, "phase(R7)", int'(rd_data[5:4]), m_ph);
        chk(req, "spare", int'({rd_data[7:6], rd_data[2]}), 0);
        chk(req, "irq(R10)", int'(irq), int'(m_irq));
    endtask

    // one clock: drive, model, compare after the edge
    task automatic step(input bit we, input logic [DW-1:0] wd, input bit rx,
                        input bit tx, input string req);
        bit arm, rel, des, txev, ev;
        wr_en = we; wr_data = wd; pkt_rx = rx; pkt_tx_done = tx;
        arm  = we && wd[1];
        rel  = we && wd[6] && m_rx;
        des  = we && wd[3] && (arm || rel);
        txev = tx && m_tx;
        ev   = rx || txev;
        @(posedge clk);
        case (m_ph)
            0: if (rx) m_ph = 2; else if (arm) m_ph = 1;
            1: if (txev && m_de) m_ph = 0;
            2: if (rel && des) m_ph = 0;
            default: m_ph = 0;
        endcase
        m_irq = ev;
        if (rx) m_rx = 1; else if (rel) m_rx = 0;
        if (arm) m_tx = 1; else if (txev) m_tx = 0;
        if (des) m_de = 1; else if (ev) m_de = 0;
        #2;
        wr_en = 0; wr_data = '0; pkt_rx = 0; pkt_tx_done = 0;
        compare(req);
    endtask

    localparam logic [DW-1:0] ARM = 8'h02, DE = 8'h08, REL = 8'h40;

    initial begin : watchdog
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        m_rx = 0; m_tx = 0; m_de = 0; m_irq = 0; m_ph = 0;
        compare("R1");
        rst = 0;
        // IN data stage: two packets, last one flagged (R9)
        step(1, ARM, 0, 0, "R3");
        step(0, 0, 0, 1, "R9");          // DataEnd 0: stays TX
        step(1, ARM | DE, 0, 0, "R4");
        step(0, 0, 0, 1, "R9");          // returns IDLE, DataEnd clears
        // zero-length packet with DataEnd
        step(1, ARM | DE, 0, 0, "R4");
        step(0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, "R5");
        step(0, 0, 0, 1, "R3");          // completion when not armed: ignored
        // ignored writes (R4)
        step(1, DE, 0, 0, "R4");
        step(1, DE | REL, 0, 0, "R4");   // no packet held
        step(1, 8'h00, 0, 0, "R4");
        // OUT data stage (R8)
        step(0, 0, 1, 0, "R7");
        step(1, REL, 0, 0, "R8");        // stays RX
        step(0, 0, 1, 0, "R2");
        step(1, 8'h00, 0, 0, "R2");      // write 0: no effect
        step(1, REL | DE, 0, 0, "R8");   // back to IDLE
        step(0, 0, 1, 0, "R5");          // new packet clears DataEnd
        // collision: release+DataEnd with incoming packet (R6)
        step(1, REL | DE, 1, 0, "R6");
        step(0, 0, 0, 0, "R6");
        step(1, REL, 0, 0, "R2");
        step(0, 0, 1, 0, "R6");          // following event clears
        step(1, REL | DE, 0, 0, "R8");
        // collision: arm+DataEnd with completion (R6)
        step(1, ARM, 0, 0, "R7");
        step(1, ARM | DE, 0, 1, "R6");
        step(0, 0, 0, 1, "R6");
        // both events in one cycle: one pulse (R10)
        step(1, ARM, 0, 0, "R10");
        step(0, 0, 1, 1, "R10");
        step(0, 0, 0, 0, "R10");
        // randomized stretch
        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] w;
            w = '0;
            w[1] = ($urandom_range(0, 3) == 0);
            w[3] = ($urandom_range(0, 1) == 0);
            w[6] = ($urandom_range(0, 2) == 0);
            step($urandom_range(0, 1) == 1, w, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 2) == 0, "R6");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule